// File: doc/BRIEF.md
# SPI Serial Clock and Select Timing Generator

This block sets the timing of one SPI frame on the controller side. A single-cycle `start_i` latches a configuration word. Select (`sel_o`) then goes active and is held for a programmable lead interval. The serial clock then makes two transitions per frame bit. Select stays active for a programmable trail interval after the last transition, then drops, and `done_o` pulses. Data shifting, FIFOs and register access sit outside this block. They use the `sample_o` and `shift_o` strobes, which mark each clock transition according to the phase setting.

The serial clock period is not a plain counter divide. It is the product of a small prime prescaler (2, 3, 5 or 7) and a non-uniform scaler (2, 4, 6, 8, then powers of two up to 32768). The lead and trail intervals each come from their own prescaler/scaler pair. For these, the prescaler is odd (1, 3, 5 or 7) and the scaler is a power of two, 2^(n+1).

Top module: `spi_tmg_gen`

## Requirements
- R1: While reset is held, `sel_o`, `done_o`, `sample_o` and `shift_o` are low and `sck_o` equals `cpol_i`.
- R2: The clock period in system clocks is P = B × S. B is 2, 3, 5 or 7 for `baud_pre_i` = 0..3. S is 2, 4, 6 or 8 for `baud_scl_i` = 0..3 and 2^k for `baud_scl_i` = k in 4..15.
- R3: The interval after an odd-numbered clock transition lasts floor(P/2) cycles, and the interval after an even-numbered one lasts P − floor(P/2) cycles.
- R4: The first `sck_o` transition comes L cycles after `sel_o` rises. L = (2·`lead_pre_i`+1) × 2^(`lead_scl_i`+1).
- R5: `sel_o` falls D cycles after the last `sck_o` transition. D = (2·`trail_pre_i`+1) × 2^(`trail_scl_i`+1).
- R6: A frame makes exactly 2×(`frame_len_i`+1) transitions of `sck_o`. The field holds the bit count minus one.
- R7: While `sel_o` is low, `sck_o` follows `cpol_i` in the same cycle. Each frame ends with `sck_o` back at that level.
- R8: Exactly one of `sample_o`/`shift_o` is high in each cycle where `sck_o` changes during a frame, and neither is high in any other cycle. With phase 0, odd transitions sample and even ones shift. With phase 1 the roles are swapped.
- R9: `done_o` is high for exactly one cycle, and that cycle is the first one with `sel_o` low after a frame.
- R10: `start_i` while a frame is active has no effect, and changes to the configuration inputs during a frame do not alter that frame.
- R11: A `start_i` held during the `done_o` cycle is accepted, so `sel_o` is low for exactly one cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (accepted when idle) |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase: which transitions sample |
| frame_len_i | input | 4 | Bits per frame minus one |
| baud_pre_i | input | 2 | Clock prescaler index |
| baud_scl_i | input | 4 | Clock scaler index |
| lead_pre_i | input | 2 | Select-to-clock delay prescaler index |
| lead_scl_i | input | 4 | Select-to-clock delay scaler index |
| trail_pre_i | input | 2 | Clock-to-deselect delay prescaler index |
| trail_scl_i | input | 4 | Clock-to-deselect delay scaler index |
| sck_o | output | 1 | Serial clock |
| sel_o | output | 1 | Select, active high |
| sample_o | output | 1 | Strobe on transitions that capture data |
| shift_o | output | 1 | Strobe on transitions that launch data |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The end-of-frame pulse and the acceptance of a new start can fall in the same cycle. In that cycle the sequencer has just returned to idle and samples `start_i` again. The bench watches for `done_o` at a falling clock edge and raises `start_i` at once, so the next rising edge sees both. It then judges the result by the width of the `sel_o` low gap, which must be exactly one cycle. It also checks that the second frame's lead interval and transition count are correct.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

    localparam int unsigned PRE_W = 2;
    localparam int unsigned SCL_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_CLOCK = 2'd2,
        ST_TRAIL = 2'd3
    } tmg_state_e;

    // clock prescaler: small primes
    function automatic logic [31:0] baud_pre_val(input logic [PRE_W-1:0] idx);
        logic [31:0] v;
        case (idx)
            2'd0:    v = 32'd2;
            2'd1:    v = 32'd3;
            2'd2:    v = 32'd5;
            default: v = 32'd7;
        endcase
        return v;
    endfunction

    // clock scaler: linear steps below index 4, powers of two above
    function automatic logic [31:0] baud_scl_val(input logic [SCL_W-1:0] idx);
        logic [31:0] v;
        if (idx < 4'd4) v = 32'd2 * (32'(idx) + 32'd1);
        else            v = 32'd1 << idx;
        return v;
    endfunction

    // delay prescaler: odd values
    function automatic logic [31:0] dly_pre_val(input logic [PRE_W-1:0] idx);
        return 32'd2 * 32'(idx) + 32'd1;
    endfunction

    // delay scaler: 2^(n+1)
    function automatic logic [31:0] dly_scl_val(input logic [SCL_W-1:0] idx);
        return 32'd2 << idx;
    endfunction

endpackage

// File: rtl/spi_tmg_ratio.sv
module spi_tmg_ratio
    import spi_tmg_pkg::*;
#(
    parameter int unsigned CNT_W = 19
) (
    input  logic [PRE_W-1:0] baud_pre_i,
    input  logic [SCL_W-1:0] baud_scl_i,
    input  logic [PRE_W-1:0] lead_pre_i,
    input  logic [SCL_W-1:0] lead_scl_i,
    input  logic [PRE_W-1:0] trail_pre_i,
    input  logic [SCL_W-1:0] trail_scl_i,
    output logic [CNT_W-1:0] half_a_o,
    output logic [CNT_W-1:0] half_b_o,
    output logic [CNT_W-1:0] lead_len_o,
    output logic [CNT_W-1:0] trail_len_o
);

    localparam int unsigned N_DLY = 2;

    logic [CNT_W-1:0] period;
    logic [PRE_W-1:0] dpre [N_DLY];
    logic [SCL_W-1:0] dscl [N_DLY];
    logic [CNT_W-1:0] dlen [N_DLY];

    always_comb begin
        period   = CNT_W'(baud_pre_val(baud_pre_i) * baud_scl_val(baud_scl_i));
        half_a_o = period >> 1;
        half_b_o = period - (period >> 1);
    end

    assign dpre[0] = lead_pre_i;
    assign dscl[0] = lead_scl_i;
    assign dpre[1] = trail_pre_i;
    assign dscl[1] = trail_scl_i;

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        assign dlen[g] = CNT_W'(dly_pre_val(dpre[g]) * dly_scl_val(dscl[g]));
    end

    assign lead_len_o  = dlen[0];
    assign trail_len_o = dlen[1];

endmodule

// File: rtl/spi_tmg_cnt.sv
module spi_tmg_cnt #(
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_tmg_phase.sv
module spi_tmg_phase (
    input  logic fire_i,
    input  logic odd_edge_i,
    input  logic cpha_i,
    output logic sample_o,
    output logic shift_o
);

    logic capture;

    always_comb begin
        capture  = odd_edge_i ^ cpha_i;
        sample_o = fire_i & capture;
        shift_o  = fire_i & ~capture;
    end

endmodule

// File: rtl/spi_tmg_gen.sv
module spi_tmg_gen
    import spi_tmg_pkg::*;
#(
    parameter int unsigned FRAME_W = 4,
    parameter int unsigned CNT_W   = 19
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic [FRAME_W-1:0] frame_len_i,
    input  logic [PRE_W-1:0]   baud_pre_i,
    input  logic [SCL_W-1:0]   baud_scl_i,
    input  logic [PRE_W-1:0]   lead_pre_i,
    input  logic [SCL_W-1:0]   lead_scl_i,
    input  logic [PRE_W-1:0]   trail_pre_i,
    input  logic [SCL_W-1:0]   trail_scl_i,
    output logic               sck_o,
    output logic               sel_o,
    output logic               sample_o,
    output logic               shift_o,
    output logic               done_o
);

    localparam int unsigned EDGE_W = FRAME_W + 2;

    typedef struct packed {
        logic               cpha;
        logic [FRAME_W-1:0] flen;
        logic [PRE_W-1:0]   bpre;
        logic [SCL_W-1:0]   bscl;
        logic [PRE_W-1:0]   lpre;
        logic [SCL_W-1:0]   lscl;
        logic [PRE_W-1:0]   tpre;
        logic [SCL_W-1:0]   tscl;
    } cfg_t;

    typedef struct packed {
        tmg_state_e        st;
        cfg_t              cfg;
        logic [EDGE_W-1:0] edges;
        logic              sck;
        logic              sample;
        logic              shift;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    cfg_t             cfg_live, cfg_eff;
    logic [CNT_W-1:0] half_a, half_b, lead_len, trail_len;
    logic             cnt_load, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             fire, str_sample, str_shift;
    logic [EDGE_W-1:0] edges_tot, edges_nxt;

    always_comb begin
        cfg_live = '{cpha: cpha_i, flen: frame_len_i,
                     bpre: baud_pre_i, bscl: baud_scl_i,
                     lpre: lead_pre_i, lscl: lead_scl_i,
                     tpre: trail_pre_i, tscl: trail_scl_i};
        cfg_eff  = (r_q.st == ST_IDLE) ? cfg_live : r_q.cfg;
    end

    spi_tmg_ratio #(.CNT_W(CNT_W)) ratio_i (
        .baud_pre_i  (cfg_eff.bpre),
        .baud_scl_i  (cfg_eff.bscl),
        .lead_pre_i  (cfg_eff.lpre),
        .lead_scl_i  (cfg_eff.lscl),
        .trail_pre_i (cfg_eff.tpre),
        .trail_scl_i (cfg_eff.tscl),
        .half_a_o    (half_a),
        .half_b_o    (half_b),
        .lead_len_o  (lead_len),
        .trail_len_o (trail_len)
    );

    spi_tmg_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .zero_o     (cnt_zero)
    );

    assign fire = cnt_zero && ((r_q.st == ST_LEAD) || (r_q.st == ST_CLOCK));

    spi_tmg_phase phase_i (
        .fire_i     (fire),
        .odd_edge_i (~r_q.edges[0]),
        .cpha_i     (r_q.cfg.cpha),
        .sample_o   (str_sample),
        .shift_o    (str_shift)
    );

    always_comb begin
        edges_tot = (EDGE_W'(r_q.cfg.flen) + EDGE_W'(1)) << 1;
        edges_nxt = r_q.edges + EDGE_W'(1);
    end

    always_comb begin
        r_d        = r_q;
        r_d.sample = str_sample;
        r_d.shift  = str_shift;
        r_d.done   = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck = cpol_i;
                if (start_i) begin
                    r_d.st    = ST_LEAD;
                    r_d.cfg   = cfg_live;
                    r_d.edges = '0;
                    cnt_load  = 1'b1;
                    cnt_val   = lead_len - CNT_W'(1);
                end
            end
            ST_LEAD, ST_CLOCK: begin
                if (fire) begin
                    r_d.sck   = ~r_q.sck;
                    r_d.edges = edges_nxt;
                    cnt_load  = 1'b1;
                    if (edges_nxt == edges_tot) begin
                        r_d.st  = ST_TRAIL;
                        cnt_val = trail_len - CNT_W'(1);
                    end else begin
                        r_d.st  = ST_CLOCK;
                        cnt_val = (edges_nxt[0] ? half_a : half_b) - CNT_W'(1);
                    end
                end
            end
            ST_TRAIL: begin
                if (cnt_zero) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o    = (r_q.st != ST_IDLE);
    assign sck_o    = sel_o ? r_q.sck : cpol_i;
    assign sample_o = r_q.sample;
    assign shift_o  = r_q.shift;
    assign done_o   = r_q.done;

endmodule

// File: rtl/spi_tmg_chk.sv
module spi_tmg_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic cpol_i,
    input logic sck_o,
    input logic sel_o,
    input logic sample_o,
    input logic shift_o,
    input logic done_o
);

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9
    AST_DONE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !sel_o); // R9
    AST_DESELECT_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sel_o) |-> done_o); // R9
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && shift_o)); // R8
    AST_STROBE_ON_TRANSITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o || shift_o) |-> (sel_o && $past(sel_o) && sck_o != $past(sck_o))); // R8
    AST_TRANSITION_HAS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o && $past(sel_o) && sck_o != $past(sck_o)) |-> (sample_o || shift_o)); // R8
    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_o |-> (sck_o == cpol_i)); // R7
    AST_SELECT_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_o) |-> $past(start_i)); // R10

endmodule

bind spi_tmg_gen spi_tmg_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cpol_i   (cpol_i),
    .sck_o    (sck_o),
    .sel_o    (sel_o),
    .sample_o (sample_o),
    .shift_o  (shift_o),
    .done_o   (done_o)
);

// File: tb/spi_tmg_gen_tb.sv
module spi_tmg_gen_tb_top;

    typedef struct packed {
        logic [1:0] bpre;
        logic [3:0] bscl;
        logic [1:0] lpre;
        logic [3:0] lscl;
        logic [1:0] tpre;
        logic [3:0] tscl;
        logic       cpol;
        logic       cpha;
        logic [3:0] flen;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 1'b0, 1'b0, 4'd7},
        '{2'd1, 4'd0, 2'd1, 4'd0, 2'd2, 4'd1, 1'b1, 1'b0, 4'd3},
        '{2'd2, 4'd1, 2'd3, 4'd2, 2'd0, 4'd3, 1'b0, 1'b1, 4'd4},
        '{2'd3, 4'd2, 2'd2, 4'd1, 2'd1, 4'd2, 1'b1, 1'b1, 4'd0},
        '{2'd1, 4'd4, 2'd0, 4'd4, 2'd3, 4'd0, 1'b0, 1'b0, 4'd15},
        '{2'd3, 4'd6, 2'd3, 4'd9, 2'd3, 4'd9, 1'b1, 1'b0, 4'd0},
        '{2'd0, 4'd5, 2'd1, 4'd3, 2'd2, 4'd2, 1'b0, 1'b1, 4'd1}
    };
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0;
    logic [3:0] flen = '0;
    logic [1:0] bpre = '0, lpre = '0, tpre = '0;
    logic [3:0] bscl = '0, lscl = '0, tscl = '0;
    logic sck, sel, sample, shift, done;

    always #4 clk = ~clk;

    spi_tmg_gen dut_i (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start),
        .cpol_i (cpol), .cpha_i (cpha), .frame_len_i (flen),
        .baud_pre_i (bpre), .baud_scl_i (bscl),
        .lead_pre_i (lpre), .lead_scl_i (lscl),
        .trail_pre_i (tpre), .trail_scl_i (tscl),
        .sck_o (sck), .sel_o (sel), .sample_o (sample),
        .shift_o (shift), .done_o (done)
    );

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bpre_v(input logic [1:0] i);
        case (i) 2'd0: return 2; 2'd1: return 3; 2'd2: return 5; default: return 7; endcase
    endfunction
    function automatic int bscl_v(input logic [3:0] i);
        case (i)
            4'd0: return 2;     4'd1: return 4;     4'd2: return 6;      4'd3: return 8;
            4'd4: return 16;    4'd5: return 32;    4'd6: return 64;     4'd7: return 128;
            4'd8: return 256;   4'd9: return 512;   4'd10: return 1024;  4'd11: return 2048;
            4'd12: return 4096; 4'd13: return 8192; 4'd14: return 16384; default: return 32768;
        endcase
    endfunction
    function automatic int dly_v(input logic [1:0] p, input logic [3:0] s);
        return (2 * int'(p) + 1) * (2 ** (int'(s) + 1));
    endfunction

    // monitor, sampled on falling edges
    int  cyc = 0;
    logic prev_sck = 1'b0, prev_sel = 1'b0, prev_done = 1'b0;
    int  t_rise = 0, t_fall = 0, t_last = 0;
    int  edge_n = 0, lead_m = 0, trail_m = 0, gap_m = 0;
    int  halves [32];
    int  strobe_err = 0, done_cnt = 0, done_long = 0, done_sel_err = 0, rises = 0;
    logic cur_cpha = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sel && !prev_sel) begin
                t_rise = cyc; edge_n = 0; gap_m = cyc - t_fall; rises++;
            end
            if (sel && prev_sel && sck != prev_sck) begin
                edge_n++;
                if (edge_n == 1) lead_m = cyc - t_rise;
                else if (edge_n <= 32) halves[edge_n - 2] = cyc - t_last;
                t_last = cyc;
                if (sample != ((edge_n % 2 == 1) ^ cur_cpha) || shift == sample)
                    strobe_err++;
            end else if (sample || shift) begin
                strobe_err++;
            end
            if (!sel && prev_sel) begin
                trail_m = cyc - t_last; t_fall = cyc;
                if (!done) done_sel_err++;
            end
            if (done) begin
                done_cnt++;
                if (prev_done) done_long++;
                if (sel) done_sel_err++;
            end
        end
        prev_sck = sck; prev_sel = sel; prev_done = done;
        if (cyc > WD_LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic apply(input vec_t v);
        bpre = v.bpre; bscl = v.bscl; lpre = v.lpre; lscl = v.lscl;
        tpre = v.tpre; tscl = v.tscl; cpol = v.cpol; cpha = v.cpha; flen = v.flen;
        cur_cpha = v.cpha;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic judge(input vec_t v);
        int p, ha, bad, first_bad, exp_h;
        p = bpre_v(v.bpre) * bscl_v(v.bscl);
        ha = p / 2;
        check(lead_m == dly_v(v.lpre, v.lscl), "R4 lead", lead_m, dly_v(v.lpre, v.lscl));
        check(trail_m == dly_v(v.tpre, v.tscl), "R5 trail", trail_m, dly_v(v.tpre, v.tscl));
        check(edge_n == 2 * (int'(v.flen) + 1), "R6 edges", edge_n, 2 * (int'(v.flen) + 1));
        bad = 0; first_bad = 0;
        for (int i = 0; i < edge_n - 1; i++) begin
            exp_h = (i % 2 == 0) ? ha : p - ha;  // after odd transition: floor half (R3)
            if (halves[i] != exp_h) begin
                if (bad == 0) first_bad = halves[i];
                bad++;
            end
        end
        check(bad == 0, "R3 half split", first_bad, ha);
        if (edge_n >= 3)
            check(halves[0] + halves[1] == p, "R2 period", halves[0] + halves[1], p);
        check(strobe_err == 0, "R8 strobes", strobe_err, 0);
        check(sck == v.cpol, "R7 end level", int'(sck), int'(v.cpol));
        check(done_long == 0 && done_sel_err == 0, "R9 done pulse", done_long + done_sel_err, 0);
    endtask

    initial begin
        vec_t v;
        int rb, db;
        // R1: reset values with both polarity settings
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!sel && !done && !sample && !shift, "R1 reset outputs",
              int'({sel, done, sample, shift}), 0);
        check(sck == 1'b1, "R1 reset sck high", int'(sck), 1);
        cpol = 1'b0; #1;
        check(sck == 1'b0, "R1 reset sck low", int'(sck), 0);
        @(negedge clk); rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k]);
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            wait_done();
            @(negedge clk); #1;
            judge(VECS[k]);
        end

        // R7: idle level follows polarity at once
        cpol = 1'b1; #1;
        check(sck == 1'b1, "R7 idle follows cpol", int'(sck), 1);
        cpol = 1'b0; #1;
        check(sck == 1'b0, "R7 idle follows cpol", int'(sck), 0);

        // R10: start and config changes mid-frame are ignored
        v = VECS[2];
        apply(v);
        rb = rises; db = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; bscl = 4'd7; cpha = ~cpha; flen = 4'd9; lscl = 4'd5;
        @(negedge clk); start = 1'b0;
        wait_done();
        @(negedge clk); #1;
        judge(v);
        check(rises - rb == 1, "R10 single select", rises - rb, 1);
        check(done_cnt - db == 1, "R10 single done", done_cnt - db, 1);

        // R11: restart in the done cycle
        v = VECS[1];
        apply(v);
        rb = rises;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        @(negedge clk); #1;
        check(gap_m == 1, "R11 deselect gap", gap_m, 1);
        check(rises - rb == 2, "R11 two frames", rises - rb, 2);
        judge(v);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule